// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Debounce and Interrupt Trigger

This block owns one general-purpose I/O pin. Software reaches it through a 32-byte window of word registers: one configuration word sets the pin enable, direction, trigger mode, trigger polarity, debounce enable and interrupt enable. Separate words hold the debounce threshold, the float (tri-state) control and the output level. Another word returns the sampled input level, and a write-only word clears the latched interrupt. The pad side gives a drive value and an output enable, and takes the raw pad level.

The raw pad level passes through a synchronizer and an optional debounce filter. The filter counts a one-cycle millisecond tick supplied from outside, so the threshold is in milliseconds, up to 255. The filtered level feeds the input register and a trigger detector. The detector can fire on a level, on one edge, or on both edges. It latches a pending flag, and that flag leaves the block gated by the interrupt enable. Software clears the flag by writing. A level condition that is still present sets the flag again at once.

Top module: `pin_ctl_slice`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are 0, and `irq_pend` is 0.
- R2: Configuration word at byte offset 0x00 uses bit 0 = pin enable, bit 1 = drive as output, bits 3:2 = trigger mode, bit 4 = polarity, bit 5 = debounce enable and bit 6 = interrupt enable. All seven bits read back. The threshold at 0x04 reads back bits 7:0, the float bit at 0x0C reads back bit 0 and the output level at 0x10 reads back bit 0. Higher bits, the clear word 0x14 and the unused offsets 0x18 and 0x1C read zero.
- R3: `pad_oe` is 1 exactly when pin enable = 1, drive-as-output = 1 and float = 0. `pad_out` follows the output-level bit.
- R4: Offset 0x08 bit 0 returns the filtered input. With debounce off, or with a threshold of 0, the filtered input equals `pad_in` as it was three clock edges earlier (two synchronizer stages plus one register).
- R5: With debounce on and threshold N > 0, the filtered input takes a new synchronized value on the Nth `ms_tick` seen while the two differ. If the synchronized level returns to the filtered value, the count restarts.
- R6: Trigger mode 00 never sets the pending flag. Mode 01 (level) sets it in each cycle in which the filtered input equals the polarity bit. Mode 10 (single edge) sets it on a rising edge when polarity = 1 and on a falling edge when polarity = 0. Mode 11 sets it on either edge, whatever the polarity bit holds. Edges are taken on the filtered input.
- R7: Writing a word with bit 0 = 1 to offset 0x14 clears the pending flag at that clock edge. Writing bit 0 = 0 leaves the flag unchanged.
- R8: In level mode, the pending flag is set again after a clear for as long as the level persists.
- R9: When a trigger event and a clear write fall on the same clock edge, the pending flag ends up set.
- R10: `irq_pend` equals the pending flag ANDed with the interrupt-enable bit. Setting the enable exposes a flag that latched while the enable was off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Byte offset into the register window |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 1 | Raw pad level |
| pad_out | output | 1 | Level driven onto the pad |
| pad_oe | output | 1 | Pad driver enable |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| irq_pend | output | 1 | Gated pending interrupt |

## Verification
Two things can fall on the same edge: the software clear of the pending flag and a new trigger event from the detector. The bench toggles the pad in both-edge mode and counts the three registers between pad and detector. It then holds the clear-register write strobe across exactly the edge at which the edge detection lands. It judges the result by `irq_pend` staying high after that edge, and by a second clear then taking it low. The level-mode re-assertion case is judged the same way: a clear at a still-active level must leave `irq_pend` high.

// File: rtl/pin_ctl_pkg.sv
`timescale 1ns/1ps
package pin_ctl_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF   = 2'b00,
      TRIG_LEVEL = 2'b01,
      TRIG_EDGE  = 2'b10,
      TRIG_ANY   = 2'b11
   } trig_e;

   // packed MSB first: bit 0 is pin enable
   typedef struct packed {
      logic  irq_en;
      logic  deb_en;
      logic  pol;
      trig_e trig;
      logic  dir_out;
      logic  en;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

   localparam int unsigned OFS_CFG = 32'h00;
   localparam int unsigned OFS_DBN = 32'h04;
   localparam int unsigned OFS_INP = 32'h08;
   localparam int unsigned OFS_FLT = 32'h0C;
   localparam int unsigned OFS_OUT = 32'h10;
   localparam int unsigned OFS_CLR = 32'h14;

endpackage

// File: rtl/pin_ctl_regs.sv
`timescale 1ns/1ps
module pin_ctl_regs
   import pin_ctl_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int THR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic              filt_lvl,
   output logic [DATA_W-1:0] rdata,
   output cfg_t              cfg_q,
   output logic [THR_W-1:0]  thr_q,
   output logic              float_q,
   output logic              out_q,
   output logic              clr_pulse
);

   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_DBN = ADDR_W'(OFS_DBN);
   localparam logic [ADDR_W-1:0] A_INP = ADDR_W'(OFS_INP);
   localparam logic [ADDR_W-1:0] A_FLT = ADDR_W'(OFS_FLT);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFS_OUT);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         thr_q   <= '0;
         float_q <= 1'b0;
         out_q   <= 1'b0;
      end else if (we) begin
         case (addr)
            A_CFG:   cfg_q   <= cfg_t'(wdata[CFG_W-1:0]);
            A_DBN:   thr_q   <= wdata[THR_W-1:0];
            A_FLT:   float_q <= wdata[0];
            A_OUT:   out_q   <= wdata[0];
            default: ;
         endcase
      end
   end

   assign clr_pulse = we && (addr == A_CLR) && wdata[0];

   always_comb begin
      rdata = '0;
      case (addr)
         A_CFG:   rdata[CFG_W-1:0] = cfg_q;
         A_DBN:   rdata[THR_W-1:0] = thr_q;
         A_INP:   rdata[0]         = filt_lvl;
         A_FLT:   rdata[0]         = float_q;
         A_OUT:   rdata[0]         = out_q;
         default: rdata            = '0;
      endcase
   end

endmodule

// File: rtl/pin_ctl_filter.sv
`timescale 1ns/1ps
module pin_ctl_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int THR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pad_in,
   input  logic             ms_tick,
   input  logic             deb_en,
   input  logic [THR_W-1:0] thr,
   output logic             filt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw;
   logic [THR_W-1:0]       cnt_q;
   logic [THR_W:0]         cnt_nx;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= pad_in;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
         end
      end
   endgenerate

   assign raw    = sync_q[SYNC_STAGES-1];
   assign cnt_nx = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt  <= 1'b0;
         cnt_q <= '0;
      end else if (!deb_en || (thr == '0)) begin
         filt  <= raw;
         cnt_q <= '0;
      end else if (raw == filt) begin
         cnt_q <= '0;
      end else if (ms_tick) begin
         if (cnt_nx >= {1'b0, thr}) begin
            filt  <= raw;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_nx[THR_W-1:0];
         end
      end
   end

endmodule

// File: rtl/pin_ctl_trig.sv
`timescale 1ns/1ps
module pin_ctl_trig
   import pin_ctl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  filt,
   input  trig_e mode,
   input  logic  pol,
   input  logic  clr,
   output logic  hit,
   output logic  pend
);

   logic prev_q;
   logic rise, fall;

   assign rise = filt & ~prev_q;
   assign fall = ~filt & prev_q;

   always_comb begin
      unique case (mode)
         TRIG_OFF:   hit = 1'b0;
         TRIG_LEVEL: hit = (filt == pol);
         TRIG_EDGE:  hit = pol ? rise : fall;
         TRIG_ANY:   hit = rise | fall;
         default:    hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         prev_q <= filt;
         pend   <= hit | (pend & ~clr);
      end
   end

endmodule

// File: rtl/pin_ctl_slice.sv
`timescale 1ns/1ps
module pin_ctl_slice
   import pin_ctl_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int THR_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe,
   input  logic              ms_tick,
   output logic              irq_pend
);

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         initial $fatal(1, "pin_ctl_slice: ADDR_W must cover a 32-byte window");
      end
      if (DATA_W < CFG_W || DATA_W < THR_W) begin : g_bad_data
         initial $fatal(1, "pin_ctl_slice: DATA_W too narrow for fields");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         initial $fatal(1, "pin_ctl_slice: SYNC_STAGES must be at least 1");
      end
   endgenerate

   cfg_t             cfg_q;
   logic [THR_W-1:0] thr_q;
   logic             float_q;
   logic             out_q;
   logic             clr_w;
   logic             filt_w;
   logic             hit_w;
   logic             pend_w;

   pin_ctl_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .THR_W  (THR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .we        (reg_we),
      .filt_lvl  (filt_w),
      .rdata     (reg_rdata),
      .cfg_q     (cfg_q),
      .thr_q     (thr_q),
      .float_q   (float_q),
      .out_q     (out_q),
      .clr_pulse (clr_w)
   );

   pin_ctl_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .THR_W       (THR_W)
   ) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_in  (pad_in),
      .ms_tick (ms_tick),
      .deb_en  (cfg_q.deb_en),
      .thr     (thr_q),
      .filt    (filt_w)
   );

   pin_ctl_trig u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .filt  (filt_w),
      .mode  (cfg_q.trig),
      .pol   (cfg_q.pol),
      .clr   (clr_w),
      .hit   (hit_w),
      .pend  (pend_w)
   );

   assign pad_oe   = cfg_q.en & cfg_q.dir_out & ~float_q;
   assign pad_out  = out_q;
   assign irq_pend = pend_w & cfg_q.irq_en;

endmodule

// File: rtl/pin_ctl_chk.sv
`timescale 1ns/1ps
module pin_ctl_chk #(
   parameter int THR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             hit,
   input logic             pend,
   input logic             filt,
   input logic [1:0]       mode,
   input logic             pol,
   input logic             deb_en,
   input logic [THR_W-1:0] thr,
   input logic             ms_tick
);

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !pend);  // R7

   AST_ANY_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && !$stable(filt)) |=> pend);  // R6

   AST_FILT_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (deb_en && thr != '0 && !ms_tick) |=> $stable(filt));  // R5

   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && filt == pol) |=> pend);  // R8

endmodule

bind pin_ctl_slice pin_ctl_chk #(.THR_W(THR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr_w),
   .hit     (hit_w),
   .pend    (pend_w),
   .filt    (filt_w),
   .mode    (cfg_q.trig),
   .pol     (cfg_q.pol),
   .deb_en  (cfg_q.deb_en),
   .thr     (thr_q),
   .ms_tick (ms_tick)
);

// File: tb/pin_ctl_slice_test.sv
`timescale 1ns/1ps
module pin_ctl_slice_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic        pad_in = 1'b0;
   logic        pad_out;
   logic        pad_oe;
   logic        ms_tick = 1'b0;
   logic        irq_pend;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pin_ctl_slice uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .ms_tick   (ms_tick),
      .irq_pend  (irq_pend)
   );

   // {mode[1:0], pol, start level, end level, expected irq}
   localparam logic [5:0] VEC [12] = '{
      6'b00_1_0_1_0, 6'b01_1_0_1_1, 6'b01_1_1_0_1, 6'b01_0_1_0_1,
      6'b01_0_0_0_1, 6'b10_1_0_1_1, 6'b10_1_1_0_0, 6'b10_0_1_0_1,
      6'b10_0_0_1_0, 6'b11_0_0_1_1, 6'b11_1_1_0_1, 6'b11_1_0_0_0
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk);
      #1 reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp);
   endtask

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
   endtask

   task automatic settle(input logic lvl);
      @(negedge clk) pad_in = lvl;
      repeat (6) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, 0, "R1 cfg"); rd(5'h04, 0, "R1 thr"); rd(5'h08, 0, "R1 input");
      rd(5'h0C, 0, "R1 float"); rd(5'h10, 0, "R1 outval");
      chk("R1 pad_oe", 32'(pad_oe), 0); chk("R1 pad_out", 32'(pad_out), 0);
      chk("R1 irq", 32'(irq_pend), 0);

      // R6 trigger table, R8 re-assert after clear
      for (int i = 0; i < 12; i++) begin
         logic [5:0] v;
         logic [1:0] ty;
         v  = VEC[i];
         ty = v[5:4];
         wr(5'h00, 32'h40);
         settle(v[2]);
         wr(5'h14, 32'h1);
         wr(5'h00, 32'h40 | (32'(v[3]) << 4) | (32'(ty) << 2));
         settle(v[1]);
         @(negedge clk) chk($sformatf("R6 vector %0d", i), 32'(irq_pend), 32'(v[0]));
         wr(5'h14, 32'h1);
         @(negedge clk) chk($sformatf("R8 after clear vector %0d", i), 32'(irq_pend),
                            32'(ty == 2'b01 && v[1] == v[3]));
      end
      wr(5'h00, 32'h0);
      wr(5'h14, 32'h1);

      // R2 register map
      wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, 32'h7F, "R2 cfg readback");
      wr(5'h00, 32'h0);
      wr(5'h04, 32'h1234_56A5); rd(5'h04, 32'hA5, "R2 threshold readback");
      wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, 32'h1, "R2 float readback");
      wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, 32'h1, "R2 outval readback");
      wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, 32'h0, "R2 unused 0x18");
      rd(5'h1C, 32'h0, "R2 unused 0x1C"); rd(5'h14, 32'h0, "R2 clear reads zero");

      // R3 pad drive
      wr(5'h00, 32'h3); @(negedge clk) chk("R3 float blocks oe", 32'(pad_oe), 0);
      wr(5'h0C, 32'h0); @(negedge clk) chk("R3 oe on", 32'(pad_oe), 1);
      chk("R3 pad_out high", 32'(pad_out), 1);
      wr(5'h00, 32'h1); @(negedge clk) chk("R3 input dir no oe", 32'(pad_oe), 0);
      wr(5'h00, 32'h2); @(negedge clk) chk("R3 disabled no oe", 32'(pad_oe), 0);
      wr(5'h10, 32'h0); wr(5'h00, 32'h3);
      @(negedge clk) chk("R3 pad_out low", 32'(pad_out), 0);
      chk("R3 oe back on", 32'(pad_oe), 1);

      // R4 input latency, no debounce
      wr(5'h00, 32'h0); wr(5'h04, 32'h0); settle(1'b0);
      @(negedge clk) begin pad_in = 1'b1; reg_addr = 5'h08; end
      repeat (2) @(posedge clk);
      #1 chk("R4 after two edges", reg_rdata, 0);
      @(posedge clk);
      #1 chk("R4 after three edges", reg_rdata, 1);

      // R5 debounce with threshold 3
      wr(5'h04, 32'h3); wr(5'h00, 32'h20);
      @(negedge clk) pad_in = 1'b0; reg_addr = 5'h08;
      repeat (4) @(posedge clk);
      tick(); tick(); #1 chk("R5 two ticks hold", reg_rdata, 1);
      tick(); #1 chk("R5 third tick moves", reg_rdata, 0);
      @(negedge clk) pad_in = 1'b1; repeat (4) @(posedge clk);
      tick(); tick();
      @(negedge clk) pad_in = 1'b0; repeat (4) @(posedge clk);
      @(negedge clk) pad_in = 1'b1; repeat (4) @(posedge clk);
      tick(); tick(); #1 chk("R5 count restarted", reg_rdata, 0);
      tick(); #1 chk("R5 restart then third tick", reg_rdata, 1);
      wr(5'h04, 32'h0);
      @(negedge clk) pad_in = 1'b0; reg_addr = 5'h08;
      repeat (3) @(posedge clk);
      #1 chk("R4 threshold zero passes through", reg_rdata, 0);

      // R10 gating, R7 clear semantics
      wr(5'h00, 32'h0C); settle(1'b1);
      @(negedge clk) chk("R10 gated off", 32'(irq_pend), 0);
      wr(5'h00, 32'h4C); @(negedge clk) chk("R10 latched flag exposed", 32'(irq_pend), 1);
      wr(5'h14, 32'h0); @(negedge clk) chk("R7 write zero keeps flag", 32'(irq_pend), 1);
      wr(5'h14, 32'h1); @(negedge clk) chk("R7 clear drops flag", 32'(irq_pend), 0);

      // R9 clear and edge on the same edge
      @(negedge clk) pad_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) begin reg_addr = 5'h14; reg_wdata = 32'h1; reg_we = 1'b1; end
      @(posedge clk); #1 reg_we = 1'b0;
      @(negedge clk) chk("R9 set wins over clear", 32'(irq_pend), 1);
      wr(5'h14, 32'h1); @(negedge clk) chk("R9 later clear", 32'(irq_pend), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nvec++; nbad++;
         $display("FAIL watchdog: got hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule